// File: doc/BRIEF.md
# Single-Line Write-Through L1 Controller

This block controls a private cache that holds exactly one line. It sits between a processor request port and the coherence fabric that leads to the directory. It tracks only addresses; line data is not stored. Reads that hit the held line are answered locally. Reads that miss are sent to the directory, and the processor is answered when the read response returns. Writes are always forwarded, because the cache is write-through. The line stays valid across a write, and the processor is answered only when the write response comes back.

The fabric side has several message channels. One channel carries outgoing read and write requests. One carries outgoing cleanups and update acknowledgements. Incoming read and write responses, incoming coherence requests (updates, multicast invalidates and broadcast invalidates) and incoming cleanup acknowledgements each have a channel of their own. When the line is evicted or invalidated, the controller sends a cleanup. It issues no new read until that cleanup has been acknowledged. An invalidate can race with an outstanding read for the same address. In that case the controller sends a cleanup, throws the returning response away, and re-reads the line once the acknowledgement has arrived.

Every channel is valid/ready. A message transfers on a clock edge where both valid and ready are high. An outgoing valid, once raised, stays high with stable fields until ready is seen. The processor response is held in the same way until `cpu_rsp_ready`. The controller keeps `drsp_ready` and `ack_ready` permanently high. `cin_ready` is high only while the outgoing coherence slot is empty and no data response is being offered. The 3-bit controller id is captured from `cfg_id` while reset is held. It is stamped on every outgoing message, and incoming directed messages whose destination differs from it are consumed with no effect.

Top module: `l1_line_ctrl`

## Requirements
- R1: After reset the line is empty, `cpu_req_ready` is 1 while no fabric input is valid, and `dreq_valid`, `cpr_valid` and `cpu_rsp_valid` are 0.
- R2: A read from the empty state sends one read request (`dreq_write`=0, `dreq_addr` = request address) and answers the processor (`cpu_rsp_write`=0) only after a read response (`drsp_write`=0) addressed to this controller. A later read of the same address is answered with no fabric request.
- R3: A read to a different address while the line is valid first sends a cleanup (`cpr_upd_ack`=0) carrying the old address. No read request appears until a cleanup acknowledgement addressed to this controller arrives; after it, the read for the new address is sent.
- R4: A processor write is forwarded as a write request (`dreq_write`=1). The processor is answered (`cpu_rsp_write`=1) only after a write response (`drsp_write`=1). A valid line stays valid across the write.
- R5: An invalidate that matches the held valid line sends a cleanup for that address and drops the line. This holds for a multicast invalidate (`cin_kind`=1) addressed to this controller and for a broadcast invalidate (`cin_kind`=2). A broadcast invalidate for any other address has no effect.
- R6: An update (`cin_kind`=0) addressed to this controller is answered with an update acknowledgement (`cpr_upd_ack`=1) that echoes the update address, whatever the line state.
- R7: An invalidate for the saved address that arrives while a read is outstanding sends a cleanup for that address. The read response that follows gives no processor response, and the read is re-issued only after the cleanup acknowledgement.
- R8: Multicast invalidates and updates whose `cin_dest` differs from the controller id produce no output and leave the line unchanged.
- R9: Only one processor request is outstanding. After a request is accepted, `cpu_req_ready` stays 0 until the processor response has been taken.
- R10: `dreq_valid`, `cpr_valid` and `cpu_rsp_valid` stay high with stable fields while their ready is 0.
- R11: The id is captured while `rst_n` is 0. A later change of `cfg_id` changes neither `dreq_src` nor `cpr_src`, nor which directed messages are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; id captured while low |
| cfg_id | input | ID_W | Controller id, sampled during reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request ready |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request line address |
| cpu_rsp_valid | output | 1 | Processor response valid |
| cpu_rsp_ready | input | 1 | Processor response ready |
| cpu_rsp_write | output | 1 | 1 = write completion, 0 = read completion |
| dreq_valid | output | 1 | Outgoing read/write request valid |
| dreq_ready | input | 1 | Outgoing request ready |
| dreq_write | output | 1 | 1 = write, 0 = read |
| dreq_addr | output | ADDR_W | Request address |
| dreq_src | output | ID_W | Sender id |
| drsp_valid | input | 1 | Incoming data response valid |
| drsp_ready | output | 1 | Always 1 |
| drsp_write | input | 1 | 1 = write response, 0 = read response |
| drsp_dest | input | ID_W | Destination id |
| cin_valid | input | 1 | Incoming coherence request valid |
| cin_ready | output | 1 | Coherence request ready |
| cin_kind | input | 2 | 0 update, 1 multicast invalidate, 2 broadcast invalidate, 3 ignored |
| cin_addr | input | ADDR_W | Line address of the coherence request |
| cin_dest | input | ID_W | Destination id (not used for broadcast) |
| cpr_valid | output | 1 | Outgoing cleanup / update acknowledgement valid |
| cpr_ready | input | 1 | Outgoing coherence response ready |
| cpr_upd_ack | output | 1 | 1 = update acknowledgement, 0 = cleanup |
| cpr_addr | output | ADDR_W | Line address |
| cpr_src | output | ID_W | Sender id |
| ack_valid | input | 1 | Cleanup acknowledgement valid |
| ack_ready | output | 1 | Always 1 |
| ack_dest | input | ID_W | Destination id |

## Verification
The main function is exercised through read sequences of three kinds: repeated reads of one address, which should hit locally; reads that alternate between addresses, which force victim cleanups; and reads issued from the empty state. Together they separate hit, eviction and cold-miss handling. Invalidates and updates are sent with matching and non-matching addresses, as multicasts with this controller's id or another id, and as broadcasts. This shows that address, destination and kind each gate the response on their own account. Directed cases place an invalidate inside an outstanding read, hold back each ready so the held-message rule can be checked, and change `cfg_id` after reset. A seeded random mix of all operations is then checked against a bench model of the line's validity and address.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
  typedef enum logic [2:0] {
    S_EMPTY,
    S_VALID,
    S_MISS_HOLD,
    S_MISS_WAIT,
    S_MISS_RETRY,
    S_ZOMBIE,
    S_WR_WAIT_V,
    S_WR_WAIT_E
  } ctl_state_e;

  localparam logic [1:0] CIN_UPDATE = 2'd0;
  localparam logic [1:0] CIN_MINVAL = 2'd1;
  localparam logic [1:0] CIN_BINVAL = 2'd2;

  localparam logic KIND_READ    = 1'b0;
  localparam logic KIND_WRITE   = 1'b1;
  localparam logic KIND_CLEANUP = 1'b0;
  localparam logic KIND_UPDACK  = 1'b1;
endpackage

// File: rtl/l1c_id_hold.sv
module l1c_id_hold #(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] cfg_id,
  output logic [ID_W-1:0] my_id
);
  always_ff @(posedge clk) begin
    if (!rst_n) my_id <= cfg_id;
  end
endmodule

// File: rtl/l1c_msg_decode.sv
module l1c_msg_decode
  import l1c_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 3
) (
  input  logic [ID_W-1:0]   my_id,
  input  logic [1:0]        cin_kind,
  input  logic [ADDR_W-1:0] cin_addr,
  input  logic [ID_W-1:0]   cin_dest,
  input  logic [ID_W-1:0]   drsp_dest,
  input  logic [ID_W-1:0]   ack_dest,
  input  logic [ADDR_W-1:0] cached_addr,
  input  logic [ADDR_W-1:0] saved_addr,
  output logic              upd_mine,
  output logic              inv_hit_cached,
  output logic              inv_hit_saved,
  output logic              drsp_mine,
  output logic              ack_mine
);
  logic directed_mine;
  logic inv_any;

  always_comb begin
    directed_mine  = (cin_dest == my_id);
    upd_mine       = (cin_kind == CIN_UPDATE) && directed_mine;
    inv_any        = ((cin_kind == CIN_MINVAL) && directed_mine) ||
                     (cin_kind == CIN_BINVAL);
    inv_hit_cached = inv_any && (cin_addr == cached_addr);
    inv_hit_saved  = inv_any && (cin_addr == saved_addr);
    drsp_mine      = (drsp_dest == my_id);
    ack_mine       = (ack_dest == my_id);
  end
endmodule

// File: rtl/l1c_out_slot.sv
module l1c_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         free
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign free = !out_valid;

  // R10: a held message keeps its valid and its fields until taken
  a_r10_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: the controller never loads over a message still waiting
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/l1c_ctrl_fsm.sv
module l1c_ctrl_fsm
  import l1c_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int SLOT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic              cpu_rsp_write,
  input  logic              drsp_valid,
  input  logic              drsp_write,
  input  logic              drsp_mine,
  input  logic              cin_valid,
  output logic              cin_ready,
  input  logic [ADDR_W-1:0] cin_addr,
  input  logic              upd_mine,
  input  logic              inv_hit_cached,
  input  logic              inv_hit_saved,
  input  logic              ack_valid,
  input  logic              ack_mine,
  input  logic              dreq_free,
  input  logic              cpr_free,
  output logic              dreq_load,
  output logic [SLOT_W-1:0] dreq_load_data,
  output logic              cpr_load,
  output logic [SLOT_W-1:0] cpr_load_data,
  output logic [ADDR_W-1:0] cached_addr,
  output logic [ADDR_W-1:0] saved_addr
);
  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cached_d, saved_d;
  logic              pend_q, set_pend;
  logic              rsp_valid_q, rsp_write_q, rsp_set, rsp_wr;
  logic              cpu_fire, cin_fire, drsp_fire, ack_fire;

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_write = rsp_write_q;

  always_comb begin
    cpu_req_ready = ((state_q == S_EMPTY) || (state_q == S_VALID)) &&
                    !rsp_valid_q && dreq_free && cpr_free &&
                    !cin_valid && !drsp_valid;
    cin_ready     = cpr_free && !drsp_valid;
    cpu_fire      = cpu_req_valid && cpu_req_ready;
    cin_fire      = cin_valid && cin_ready;
    drsp_fire     = drsp_valid && drsp_mine;
    ack_fire      = ack_valid && ack_mine;
  end

  always_comb begin
    state_d        = state_q;
    cached_d       = cached_addr;
    saved_d        = saved_addr;
    dreq_load      = 1'b0;
    dreq_load_data = '0;
    cpr_load       = 1'b0;
    cpr_load_data  = '0;
    set_pend       = 1'b0;
    rsp_set        = 1'b0;
    rsp_wr         = 1'b0;

    // coherence requests
    if (cin_fire) begin
      if (upd_mine) begin
        cpr_load      = 1'b1;
        cpr_load_data = {KIND_UPDACK, cin_addr};
      end else begin
        unique case (state_q)
          S_VALID, S_WR_WAIT_V: begin
            if (inv_hit_cached) begin
              cpr_load      = 1'b1;
              cpr_load_data = {KIND_CLEANUP, cached_addr};
              set_pend      = 1'b1;
              state_d       = (state_q == S_VALID) ? S_ZOMBIE : S_WR_WAIT_E;
            end
          end
          S_MISS_WAIT: begin
            if (inv_hit_saved) begin
              cpr_load      = 1'b1;
              cpr_load_data = {KIND_CLEANUP, saved_addr};
              set_pend      = 1'b1;
              state_d       = S_MISS_RETRY;
            end
          end
          default: ;
        endcase
      end
    end

    // data responses
    if (drsp_fire) begin
      if (drsp_write == KIND_READ) begin
        if (state_q == S_MISS_WAIT) begin
          state_d  = S_VALID;
          cached_d = saved_addr;
          rsp_set  = 1'b1;
          rsp_wr   = 1'b0;
        end else if (state_q == S_MISS_RETRY) begin
          state_d = S_MISS_HOLD;
        end
      end else begin
        if (state_q == S_WR_WAIT_V) begin
          state_d = S_VALID;
          rsp_set = 1'b1;
          rsp_wr  = 1'b1;
        end else if (state_q == S_WR_WAIT_E) begin
          state_d = S_EMPTY;
          rsp_set = 1'b1;
          rsp_wr  = 1'b1;
        end
      end
    end

    // cleanup acknowledgement closes a zombie line
    if (ack_fire && (state_q == S_ZOMBIE)) state_d = S_EMPTY;

    // re-issue or first issue of a read once no cleanup is in flight
    if ((state_q == S_MISS_HOLD) && !pend_q && dreq_free) begin
      dreq_load      = 1'b1;
      dreq_load_data = {KIND_READ, saved_addr};
      state_d        = S_MISS_WAIT;
    end

    // processor requests
    if (cpu_fire) begin
      if (cpu_req_write) begin
        dreq_load      = 1'b1;
        dreq_load_data = {KIND_WRITE, cpu_req_addr};
        state_d        = (state_q == S_VALID) ? S_WR_WAIT_V : S_WR_WAIT_E;
      end else if ((state_q == S_VALID) && (cpu_req_addr == cached_addr)) begin
        rsp_set = 1'b1;
        rsp_wr  = 1'b0;
      end else begin
        if (state_q == S_VALID) begin
          cpr_load      = 1'b1;
          cpr_load_data = {KIND_CLEANUP, cached_addr};
          set_pend      = 1'b1;
        end
        saved_d = cpu_req_addr;
        state_d = S_MISS_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_EMPTY;
      cached_addr <= '0;
      saved_addr  <= '0;
    end else begin
      state_q     <= state_d;
      cached_addr <= cached_d;
      saved_addr  <= saved_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (set_pend) pend_q <= 1'b1;
    else if (ack_fire) pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_write_q <= 1'b0;
    end else if (rsp_set) begin
      rsp_valid_q <= 1'b1;
      rsp_write_q <= rsp_wr;
    end else if (rsp_valid_q && cpu_rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  // R3, R7: no read leaves while a cleanup is unacknowledged
  a_r3_read_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_load && (dreq_load_data[SLOT_W-1] == KIND_READ)) |-> !pend_q);

  // R2: a valid line never coexists with an outstanding cleanup
  a_r2_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_VALID) |-> !pend_q);

  // R5: a dropped line always waits for its acknowledgement
  a_r5_zombie_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ZOMBIE) |-> pend_q);

  // R9: an accepted request closes the port on the next cycle
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fire |=> !cpu_req_ready);

  // R10: the processor response waits for its ready
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_write)));
endmodule

// File: rtl/l1_line_ctrl.sv
module l1_line_ctrl
  import l1c_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic              cpu_rsp_write,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic              dreq_write,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [ID_W-1:0]   dreq_src,
  input  logic              drsp_valid,
  output logic              drsp_ready,
  input  logic              drsp_write,
  input  logic [ID_W-1:0]   drsp_dest,
  input  logic              cin_valid,
  output logic              cin_ready,
  input  logic [1:0]        cin_kind,
  input  logic [ADDR_W-1:0] cin_addr,
  input  logic [ID_W-1:0]   cin_dest,
  output logic              cpr_valid,
  input  logic              cpr_ready,
  output logic              cpr_upd_ack,
  output logic [ADDR_W-1:0] cpr_addr,
  output logic [ID_W-1:0]   cpr_src,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [ID_W-1:0]   ack_dest
);
  localparam int SLOT_W = ADDR_W + 1;

  logic [ID_W-1:0]   my_id;
  logic [ADDR_W-1:0] cached_addr, saved_addr;
  logic              upd_mine, inv_hit_cached, inv_hit_saved, drsp_mine, ack_mine;
  logic              dreq_free, cpr_free, dreq_load, cpr_load;
  logic [SLOT_W-1:0] dreq_load_data, cpr_load_data, dreq_slot, cpr_slot;

  assign drsp_ready = 1'b1;
  assign ack_ready  = 1'b1;

  l1c_id_hold #(.ID_W(ID_W)) u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_id (cfg_id),
    .my_id  (my_id)
  );

  l1c_msg_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dec (
    .my_id          (my_id),
    .cin_kind       (cin_kind),
    .cin_addr       (cin_addr),
    .cin_dest       (cin_dest),
    .drsp_dest      (drsp_dest),
    .ack_dest       (ack_dest),
    .cached_addr    (cached_addr),
    .saved_addr     (saved_addr),
    .upd_mine       (upd_mine),
    .inv_hit_cached (inv_hit_cached),
    .inv_hit_saved  (inv_hit_saved),
    .drsp_mine      (drsp_mine),
    .ack_mine       (ack_mine)
  );

  l1c_ctrl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_addr   (cpu_req_addr),
    .cpu_rsp_valid  (cpu_rsp_valid),
    .cpu_rsp_ready  (cpu_rsp_ready),
    .cpu_rsp_write  (cpu_rsp_write),
    .drsp_valid     (drsp_valid),
    .drsp_write     (drsp_write),
    .drsp_mine      (drsp_mine),
    .cin_valid      (cin_valid),
    .cin_ready      (cin_ready),
    .cin_addr       (cin_addr),
    .upd_mine       (upd_mine),
    .inv_hit_cached (inv_hit_cached),
    .inv_hit_saved  (inv_hit_saved),
    .ack_valid      (ack_valid),
    .ack_mine       (ack_mine),
    .dreq_free      (dreq_free),
    .cpr_free       (cpr_free),
    .dreq_load      (dreq_load),
    .dreq_load_data (dreq_load_data),
    .cpr_load       (cpr_load),
    .cpr_load_data  (cpr_load_data),
    .cached_addr    (cached_addr),
    .saved_addr     (saved_addr)
  );

  l1c_out_slot #(.W(SLOT_W)) u_dreq_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (dreq_load),
    .load_data (dreq_load_data),
    .out_valid (dreq_valid),
    .out_ready (dreq_ready),
    .out_data  (dreq_slot),
    .free      (dreq_free)
  );

  l1c_out_slot #(.W(SLOT_W)) u_cpr_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cpr_load),
    .load_data (cpr_load_data),
    .out_valid (cpr_valid),
    .out_ready (cpr_ready),
    .out_data  (cpr_slot),
    .free      (cpr_free)
  );

  assign dreq_write  = dreq_slot[SLOT_W-1];
  assign dreq_addr   = dreq_slot[ADDR_W-1:0];
  assign dreq_src    = my_id;
  assign cpr_upd_ack = cpr_slot[SLOT_W-1];
  assign cpr_addr    = cpr_slot[ADDR_W-1:0];
  assign cpr_src     = my_id;

  // R11: the stamped id does not follow cfg_id after reset
  a_r11_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dreq_src) && $stable(cpr_src));
endmodule

// File: tb/sim_l1_line_ctrl.sv
module sim_l1_line_ctrl;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam logic [IW-1:0] MY_ID = 3'd5;
  localparam logic [IW-1:0] OTHER = 3'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] cfg_id = MY_ID;
  logic cpu_req_valid = 0, cpu_req_ready, cpu_req_write = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_rsp_valid, cpu_rsp_ready = 1, cpu_rsp_write;
  logic dreq_valid, dreq_ready = 1, dreq_write;
  logic [AW-1:0] dreq_addr;
  logic [IW-1:0] dreq_src;
  logic drsp_valid = 0, drsp_ready, drsp_write = 0;
  logic [IW-1:0] drsp_dest = '0;
  logic cin_valid = 0, cin_ready;
  logic [1:0] cin_kind = '0;
  logic [AW-1:0] cin_addr = '0;
  logic [IW-1:0] cin_dest = '0;
  logic cpr_valid, cpr_ready = 1, cpr_upd_ack;
  logic [AW-1:0] cpr_addr;
  logic [IW-1:0] cpr_src;
  logic ack_valid = 0, ack_ready;
  logic [IW-1:0] ack_dest = '0;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  bit mv = 0;
  logic [AW-1:0] ma = '0;

  always #4 clk = ~clk;

  l1_line_ctrl #(.ADDR_W(AW), .ID_W(IW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog hung act=%0d exp=0", cyc);
      finish_run();
    end
  end

  task automatic cpu_issue(input bit w, input logic [AW-1:0] a);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = w; cpu_req_addr = a;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk); #1 cpu_req_valid = 0;
  endtask

  task automatic wait_dreq(input bit w, input logic [AW-1:0] a, input string tag);
    int n = 0;
    @(negedge clk);
    while (!dreq_valid && n < 20) begin @(negedge clk); n++; end
    chk(dreq_valid, {tag, " request present"}, dreq_valid, 1);
    chk(dreq_write == w, {tag, " request kind"}, dreq_write, w);
    chk(dreq_addr == a, {tag, " request addr"}, dreq_addr, a);
    chk(dreq_src == MY_ID, {tag, " R11 request src"}, dreq_src, MY_ID);
    @(posedge clk); #1;
  endtask

  task automatic wait_cpr(input bit upd, input logic [AW-1:0] a, input string tag);
    int n = 0;
    @(negedge clk);
    while (!cpr_valid && n < 20) begin @(negedge clk); n++; end
    chk(cpr_valid, {tag, " coherence rsp present"}, cpr_valid, 1);
    chk(cpr_upd_ack == upd, {tag, " coherence rsp kind"}, cpr_upd_ack, upd);
    chk(cpr_addr == a, {tag, " coherence rsp addr"}, cpr_addr, a);
    chk(cpr_src == MY_ID, {tag, " R11 coherence src"}, cpr_src, MY_ID);
    @(posedge clk); #1;
  endtask

  task automatic wait_rsp(input bit w, input string tag);
    int n = 0;
    @(negedge clk);
    while (!cpu_rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk(cpu_rsp_valid, {tag, " cpu rsp present"}, cpu_rsp_valid, 1);
    chk(cpu_rsp_write == w, {tag, " cpu rsp kind"}, cpu_rsp_write, w);
    @(posedge clk); #1;
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dreq_valid || cpr_valid || cpu_rsp_valid) seen++;
    end
    chk(seen == 0, {tag, " no output"}, seen, 0);
    @(posedge clk); #1;
  endtask

  task automatic send_cin(input logic [1:0] k, input logic [AW-1:0] a, input logic [IW-1:0] d);
    @(negedge clk);
    cin_valid = 1; cin_kind = k; cin_addr = a; cin_dest = d;
    while (!cin_ready) @(negedge clk);
    @(posedge clk); #1 cin_valid = 0;
  endtask

  task automatic send_drsp(input bit w, input logic [IW-1:0] d);
    @(negedge clk);
    drsp_valid = 1; drsp_write = w; drsp_dest = d;
    @(posedge clk); #1 drsp_valid = 0;
  endtask

  task automatic send_ack(input logic [IW-1:0] d);
    @(negedge clk);
    ack_valid = 1; ack_dest = d;
    @(posedge clk); #1 ack_valid = 0;
  endtask

  function automatic bit inval_hits(input bit bc, input logic [AW-1:0] a, input logic [IW-1:0] d);
    return mv && (ma == a) && (bc || d == MY_ID);
  endfunction

  task automatic op_read(input logic [AW-1:0] a);
    bit hit = mv && (ma == a);
    cpu_issue(0, a);
    if (hit) begin
      wait_rsp(0, "R2 hit");
    end else begin
      if (mv) begin
        wait_cpr(0, ma, "R3 victim cleanup");
        quiet(3, "R3 read held until ack");
        send_ack(MY_ID);
      end
      wait_dreq(0, a, "R2 miss read");
      send_drsp(0, MY_ID);
      wait_rsp(0, "R2 miss rsp");
      mv = 1; ma = a;
    end
  endtask

  task automatic op_write(input logic [AW-1:0] a);
    cpu_issue(1, a);
    wait_dreq(1, a, "R4 write");
    quiet(2, "R4 no early rsp");
    send_drsp(1, MY_ID);
    wait_rsp(1, "R4 write rsp");
  endtask

  task automatic op_inval(input bit bc, input logic [AW-1:0] a, input logic [IW-1:0] d);
    bit hit = inval_hits(bc, a, d);
    send_cin(bc ? 2'd2 : 2'd1, a, d);
    if (hit) begin
      wait_cpr(0, a, "R5 inval cleanup");
      send_ack(MY_ID);
      mv = 0;
    end else begin
      quiet(3, "R5 R8 inval ignored");
    end
  endtask

  task automatic op_upd(input logic [AW-1:0] a, input logic [IW-1:0] d);
    send_cin(2'd0, a, d);
    if (d == MY_ID) wait_cpr(1, a, "R6 update ack");
    else quiet(3, "R8 foreign update");
  endtask

  initial begin
    int held;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    cfg_id = 3'd1;  // R11: changed after reset, must be ignored
    @(negedge clk);
    chk(cpu_req_ready == 1, "R1 ready after reset", cpu_req_ready, 1);
    chk(!dreq_valid && !cpr_valid && !cpu_rsp_valid, "R1 outputs idle",
        {dreq_valid, cpr_valid, cpu_rsp_valid}, 0);
    @(posedge clk); #1;

    // R2 cold miss then local hit
    op_read(16'h40);
    op_read(16'h40);
    quiet(2, "R2 hit sends nothing");
    // R3 eviction to another address
    op_read(16'h41);
    // R4 write keeps the line valid
    op_write(16'h41);
    op_read(16'h41);
    // R5 broadcast non-matching ignored, then matching drops line
    op_inval(1, 16'h77, MY_ID);
    op_read(16'h41);
    op_inval(1, 16'h41, OTHER);
    chk(mv == 0, "R5 model dropped", mv, 0);
    op_read(16'h41);
    // R8 multicast to another id ignored
    op_inval(0, 16'h41, OTHER);
    op_read(16'h41);
    op_inval(0, 16'h41, MY_ID);
    // R6 update acks regardless of state; R11 old-id filtering
    op_upd(16'h99, MY_ID);
    op_upd(16'h99, 3'd1);
    op_upd(16'h99, OTHER);

    // R7 invalidate racing an outstanding read
    cpu_issue(0, 16'h50);
    wait_dreq(0, 16'h50, "R7 first read");
    send_cin(2'd1, 16'h50, MY_ID);
    wait_cpr(0, 16'h50, "R7 race cleanup");
    send_drsp(0, MY_ID);
    quiet(4, "R7 response discarded");
    send_ack(MY_ID);
    wait_dreq(0, 16'h50, "R7 reissued read");
    send_drsp(0, MY_ID);
    wait_rsp(0, "R7 final rsp");
    mv = 1; ma = 16'h50;

    // R9 and R10 with back-pressure
    dreq_ready = 0;
    cpu_issue(1, 16'h60);
    held = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (dreq_valid && dreq_write && dreq_addr == 16'h60) held++;
      chk(cpu_req_ready == 0, "R9 ready low while busy", cpu_req_ready, 0);
    end
    chk(held == 4, "R10 request held", held, 4);
    @(posedge clk); #1 dreq_ready = 1;
    wait_dreq(1, 16'h60, "R10 released write");
    cpu_rsp_ready = 0;
    send_drsp(1, MY_ID);
    held = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cpu_rsp_valid && cpu_rsp_write) held++;
      chk(cpu_req_ready == 0, "R9 ready low until rsp taken", cpu_req_ready, 0);
    end
    chk(held >= 3, "R10 response held", held, 4);
    @(posedge clk); #1 cpu_rsp_ready = 1;
    wait_rsp(1, "R10 released rsp");
    cpr_ready = 0;
    send_cin(2'd0, 16'h33, MY_ID);
    held = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (cpr_valid && cpr_upd_ack && cpr_addr == 16'h33) held++;
    end
    chk(held == 3, "R10 coherence rsp held", held, 3);
    @(posedge clk); #1 cpr_ready = 1;
    wait_cpr(1, 16'h33, "R10 released ack");
    op_read(16'h50);

    // seeded random mix against the line model
    for (int it = 0; it < 200; it++) begin
      int r = $urandom_range(0, 9);
      logic [AW-1:0] a = 16'h40 + AW'($urandom_range(0, 3));
      logic [IW-1:0] d = ($urandom_range(0, 1) == 1) ? MY_ID : OTHER;
      if (r < 4) op_read(a);
      else if (r < 6) op_write(a);
      else if (r < 8) op_inval(r == 7, a, d);
      else op_upd(a, d);
    end

    finish_run();
  end
endmodule